// File: doc/BRIEF.md
# Configurable FPGA start-up sequencer

This block runs the last phase of device configuration. Once the configuration loader reports that all data is in, the block orders three events. It stops pulling down the open-drain DONE line. It lets go of the global set/reset that holds every internal flip-flop. It turns on the user I/O drivers. A delay setting for each event makes their relative order fully programmable: any event can come before, after or in the same cycle as another.

The block counts edges of one timing clock. A clock multiplexer outside the block selects that clock, either the configuration clock or a user clock. The block only records which source was chosen and reports it on `clk_src_o`; its behaviour is the same for both.

Two modes set how the set/reset release and the I/O enable are timed. In free-running mode, both are counted from the completion strobe. In synchronized mode, both wait until the wired-AND DONE line, sampled through a two-flop synchronizer, reads high after this device has released it. Another device on the line can therefore hold it low and stall both events for as long as it likes. All settings are captured on the completion strobe.

Top module: `startup_seq`

## Requirements
- R1: After reset and until a completion strobe is accepted, `done_pd_o`=1 (DONE pulled low), `gsr_o`=1 (set/reset held) and `io_en_o`=0.
- R2: The completion strobe is accepted when `cfg_done_i`=1 at a rising edge E0. `done_pd_o` falls at edge E0+1+d, where d is the captured `dly_done_i`. Any setting from 5 to 7 acts as 4. The default setting 0 releases DONE on the first edge after completion.
- R3: When the captured `sync_mode_i`=0 (free-running), `gsr_o` falls at edge E0+1+`dly_gsr_i` and `io_en_o` rises at edge E0+1+`dly_io_i`, with the same clamping. The level of `done_pin_i` has no effect on either.
- R4: When the captured `sync_mode_i`=1 (synchronized), neither `gsr_o` nor `io_en_o` changes while `done_pd_o`=1 or while the synchronized `done_pin_i` reads 0. This holds for any length of time.
- R5: In synchronized mode, let Ts be the third rising edge after `done_pin_i` goes high while DONE is already released (two synchronizer stages, then the trigger). `gsr_o` falls at Ts+`dly_gsr_i` and `io_en_o` rises at Ts+`dly_io_i`, with values 5 to 7 acting as 4. A setting of 0 means immediate.
- R6: An event that has fired stays in its fired state until reset, even if `done_pin_i` later goes low again. Once Ts has passed, the pending synchronized delays also complete regardless of `done_pin_i`.
- R7: The mode, the clock-source bit and all three delays are captured when the strobe is accepted. Later changes on these inputs, and later strobes, have no effect until reset.
- R8: `clk_src_o` is 0 after reset. It then shows `clk_src_i` as captured with the strobe (0 = configuration clock, 1 = user clock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock (configuration or user clock, selected outside) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_done_i | input | 1 | Configuration-complete strobe |
| sync_mode_i | input | 1 | 1 = synchronize set/reset and I/O events to the DONE line |
| clk_src_i | input | 1 | Clock-source bit: 0 configuration clock, 1 user clock |
| dly_done_i | input | 3 | DONE release delay in edges (5 to 7 act as 4) |
| dly_gsr_i | input | 3 | Set/reset release delay in edges |
| dly_io_i | input | 3 | I/O enable delay in edges |
| done_pin_i | input | 1 | Sampled level of the external wired-AND DONE line |
| done_pd_o | output | 1 | 1 = pull DONE low; 0 = release (never drives high) |
| gsr_o | output | 1 | 1 = global set/reset asserted |
| io_en_o | output | 1 | 1 = user I/O drivers enabled |
| clk_src_o | output | 1 | Captured clock-source bit |

## Verification
Timing is measured from the edge E0 that accepts the strobe. DONE release is due at E0+1+d, and in free-running mode the other two events follow the same rule. In synchronized mode the other two events are due d edges after the third edge following the rise of the DONE line. The bench computes every output for each cycle with its own model, ahead of the edge. It compares at each falling edge, half a period after the design's registers update, so a result that is one edge early or late shows up in the cycle where it happens. Long holds of the DONE line, a re-issued strobe, changed settings and a DONE drop after the trigger are each followed by a check at the outputs.

// File: rtl/startup_pkg.sv
package startup_pkg;
  localparam int NUM_EV = 3;

  typedef enum int {
    EV_DONE = 0,
    EV_GSR  = 1,
    EV_IO   = 2
  } ev_e;

  typedef struct packed {
    logic sync;
    logic clk_src;
  } mode_t;
endpackage

// File: rtl/startup_sync.sv
module startup_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int CW        = 3,
  parameter int MAXV      = 4,
  parameter int START_VAL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          active_o,
  output logic [CW-1:0] cnt_o
);
  logic          active_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_q) begin
      active_q <= 1'b1;
      cnt_q    <= CW'(START_VAL);
    end else if (active_q && (cnt_q < CW'(MAXV))) begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/startup_event.sv
module startup_event (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  output logic fired_o
);
  logic fired_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fired_q <= 1'b0;
    else if (fire_i) fired_q <= 1'b1;
  end

  assign fired_o = fired_q;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int DW          = 3,
  parameter int MAX_DLY     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_done_i,
  input  logic          sync_mode_i,
  input  logic          clk_src_i,
  input  logic [DW-1:0] dly_done_i,
  input  logic [DW-1:0] dly_gsr_i,
  input  logic [DW-1:0] dly_io_i,
  input  logic          done_pin_i,
  output logic          done_pd_o,
  output logic          gsr_o,
  output logic          io_en_o,
  output logic          clk_src_o
);
  localparam int CW = $clog2(MAX_DLY + 1);

  logic                      cfg_active;
  logic [CW-1:0]             cfg_cnt;
  logic                      sync_active;
  logic [CW-1:0]             sync_cnt;
  logic                      accept;
  logic                      pin_s;
  logic                      trig;
  logic                      mode_sync;
  mode_t                     mode_q;
  logic [NUM_EV-1:0][DW-1:0] dly_in;
  logic [NUM_EV-1:0][CW-1:0] dly_q;
  logic [NUM_EV-1:0]         fire;
  logic [NUM_EV-1:0]         fired;

  assign dly_in[EV_DONE] = dly_done_i;
  assign dly_in[EV_GSR]  = dly_gsr_i;
  assign dly_in[EV_IO]   = dly_io_i;

  assign accept = cfg_done_i & ~cfg_active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mode_q <= '0;
    else if (accept) mode_q <= '{sync: sync_mode_i, clk_src: clk_src_i};
  end

  assign mode_sync = mode_q.sync;
  assign clk_src_o = mode_q.clk_src;

  generate
    for (genvar e = 0; e < NUM_EV; e++) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly_q[e] <= '0;
        else if (accept)
          dly_q[e] <= (dly_in[e] > DW'(MAX_DLY)) ? CW'(MAX_DLY) : CW'(dly_in[e]);
      end
    end
  endgenerate

  startup_timer #(.CW(CW), .MAXV(MAX_DLY), .START_VAL(0)) u_cfg_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (accept),
    .active_o (cfg_active),
    .cnt_o    (cfg_cnt)
  );

  startup_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (done_pin_i),
    .q_o   (pin_s)
  );

  assign trig = mode_sync & fired[EV_DONE] & pin_s;

  startup_timer #(.CW(CW), .MAXV(MAX_DLY), .START_VAL(1)) u_sync_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (trig),
    .active_o (sync_active),
    .cnt_o    (sync_cnt)
  );

  assign fire[EV_DONE] = cfg_active && (cfg_cnt >= dly_q[EV_DONE]);

  generate
    for (genvar e = 1; e < NUM_EV; e++) begin : g_fire
      logic free_hit;
      logic sync_hit;
      assign free_hit = cfg_active && (cfg_cnt >= dly_q[e]);
      assign sync_hit = (trig && (dly_q[e] == '0)) ||
                        (sync_active && (sync_cnt >= dly_q[e]));
      assign fire[e]  = mode_sync ? sync_hit : free_hit;
    end

    for (genvar e = 0; e < NUM_EV; e++) begin : g_ev
      startup_event u_ev (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire[e]),
        .fired_o (fired[e])
      );
    end
  endgenerate

  assign done_pd_o = ~fired[EV_DONE];
  assign gsr_o     = ~fired[EV_GSR];
  assign io_en_o   = fired[EV_IO];
endmodule

// File: rtl/startup_chk.sv
module startup_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_done_i,
  input logic done_pd_o,
  input logic gsr_o,
  input logic io_en_o,
  input logic clk_src_o,
  input logic sync_q
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (cfg_done_i) seen_q <= 1'b1;
  end

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> (done_pd_o && gsr_o && !io_en_o));

  // R6
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_pd_o |=> !done_pd_o);

  // R6
  gsr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gsr_o |=> !gsr_o);

  // R6
  io_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_en_o |=> io_en_o);

  // R4
  sync_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q && done_pd_o) |-> (gsr_o && !io_en_o));

  // R8
  src_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |=> $stable(clk_src_o));
endmodule

bind startup_seq startup_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_done_i (cfg_done_i),
  .done_pd_o  (done_pd_o),
  .gsr_o      (gsr_o),
  .io_en_o    (io_en_o),
  .clk_src_o  (clk_src_o),
  .sync_q     (mode_sync)
);

// File: tb/sim_startup_seq.sv
`timescale 1ns/1ps
module sim_startup_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_done = 1'b0;
  logic       sync_m = 1'b0;
  logic       src = 1'b0;
  logic [2:0] dd = '0, dg = '0, di = '0;
  logic       pin_drv = 1'b0;
  logic       ext_hold = 1'b0;
  logic       done_pd, gsr, io_en, src_o;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  int m_run, m_cnt, m_rel, m_s1, m_s2, m_arm, m_scnt;
  int m_gsr_off, m_io_on, m_sync, m_src, m_dd, m_dg, m_di;

  always #4 clk = ~clk;

  startup_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_done_i(cfg_done), .sync_mode_i(sync_m),
    .clk_src_i(src), .dly_done_i(dd), .dly_gsr_i(dg), .dly_io_i(di),
    .done_pin_i(pin_drv), .done_pd_o(done_pd), .gsr_o(gsr),
    .io_en_o(io_en), .clk_src_o(src_o)
  );

  function automatic int clampd(input int v);
    return (v > 4) ? 4 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_cnt = 0; m_rel = 0; m_s1 = 0; m_s2 = 0; m_arm = 0;
      m_scnt = 0; m_gsr_off = 0; m_io_on = 0; m_sync = 0; m_src = 0;
      m_dd = 0; m_dg = 0; m_di = 0;
    end else begin
      int trig_now;
      trig_now = (m_rel != 0 && m_s2 != 0 && m_sync != 0) ? 1 : 0;
      if (m_run == 0) begin
        if (cfg_done) begin
          m_run = 1; m_cnt = 0; m_sync = int'(sync_m); m_src = int'(src);
          m_dd = clampd(int'(dd)); m_dg = clampd(int'(dg)); m_di = clampd(int'(di));
        end
      end else begin
        if (m_cnt >= m_dd) m_rel = 1;
        if (m_sync != 0) begin
          if ((trig_now != 0 && m_dg == 0) || (m_arm != 0 && m_scnt >= m_dg)) m_gsr_off = 1;
          if ((trig_now != 0 && m_di == 0) || (m_arm != 0 && m_scnt >= m_di)) m_io_on = 1;
        end else begin
          if (m_cnt >= m_dg) m_gsr_off = 1;
          if (m_cnt >= m_di) m_io_on = 1;
        end
        if (m_cnt < 4) m_cnt = m_cnt + 1;
        if (m_arm != 0) begin
          if (m_scnt < 4) m_scnt = m_scnt + 1;
        end else if (trig_now != 0) begin
          m_arm = 1; m_scnt = 1;
        end
      end
      m_s2 = m_s1;
      m_s1 = int'(pin_drv);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      string ev_req;
      ev_req = (m_run == 0) ? "R1" : ((m_sync != 0) ? "R5" : "R3");
      chk((m_run == 0) ? "R1" : "R2", "done_pd_o", int'(done_pd), (m_rel != 0) ? 0 : 1);
      chk(ev_req, "gsr_o", int'(gsr), (m_gsr_off != 0) ? 0 : 1);
      chk(ev_req, "io_en_o", int'(io_en), m_io_on);
      chk("R8", "clk_src_o", int'(src_o), m_src);
    end
    pin_drv = ~done_pd & ~ext_hold;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; cfg_done = 1'b0;
    run(2);
    rst_n = 1'b1;
    run(1);
  endtask

  task automatic strobe(input logic s, input logic c, input int a, input int b, input int d);
    sync_m = s; src = c; dd = 3'(a); dg = 3'(b); di = 3'(d);
    cfg_done = 1'b1;
    run(1);
    cfg_done = 1'b0;
  endtask

  initial begin
    do_reset();
    run(5);
    chk("R1", "idle done_pd_o", int'(done_pd), 1);
    chk("R1", "idle gsr_o", int'(gsr), 1);
    chk("R1", "idle io_en_o", int'(io_en), 0);
    chk("R8", "reset clk_src_o", int'(src_o), 0);

    // free-running, DONE line held low by another device: ignored (R3)
    ext_hold = 1'b1;
    strobe(1'b0, 1'b0, 0, 2, 4);
    run(12);
    chk("R3", "io_en_o with pin low", int'(io_en), 1);
    chk("R3", "gsr_o with pin low", int'(gsr), 0);

    // clamped settings, I/O first (R2)
    do_reset();
    ext_hold = 1'b0;
    strobe(1'b0, 1'b0, 7, 5, 0);
    run(2);
    chk("R2", "done still pulled at +2", int'(done_pd), 1);
    run(8);
    chk("R2", "done released after clamp", int'(done_pd), 0);

    // synchronized, default immediate (R5)
    do_reset();
    strobe(1'b1, 1'b0, 0, 0, 0);
    run(10);
    chk("R5", "io_en_o sync default", int'(io_en), 1);
    chk("R5", "gsr_o sync default", int'(gsr), 0);

    // synchronized with an external hold (R4, R6, R7, R8)
    do_reset();
    ext_hold = 1'b1;
    strobe(1'b1, 1'b1, 1, 3, 1);
    src = 1'b0; sync_m = 1'b0; dg = 3'd0; di = 3'd0;
    run(5);
    cfg_done = 1'b1;
    run(1);
    cfg_done = 1'b0;
    run(40);
    chk("R4", "gsr_o stalled", int'(gsr), 1);
    chk("R4", "io_en_o stalled", int'(io_en), 0);
    chk("R7", "restrobe ignored done", int'(done_pd), 0);
    chk("R8", "clk_src_o captured", int'(src_o), 1);
    ext_hold = 1'b0;
    run(4);
    ext_hold = 1'b1;
    run(10);
    chk("R6", "gsr_o after pin drop", int'(gsr), 0);
    chk("R6", "io_en_o after pin drop", int'(io_en), 1);
    chk("R7", "clk_src_o unchanged", int'(src_o), 1);

    // synchronized, DONE delayed longer than I/O, long delays
    do_reset();
    ext_hold = 1'b0;
    strobe(1'b1, 1'b0, 4, 6, 2);
    run(20);
    chk("R5", "gsr_o long sync", int'(gsr), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule